// File: doc/BRIEF.md
# Capture/Compare/PWM Unit

This block pairs one 16-bit data register with a free-running 16-bit timer and a single pin. A 4-bit mode input decides what the register is used for. In capture mode it records the timer value when a selected pin event happens. In compare mode it watches for the timer to equal the register and then acts on the pin. In PWM mode its low bits set the duty value of a waveform built on a 10-bit timebase, which is an 8-bit period timer extended by 2 fractional bits. A sticky interrupt flag reports captures and compare matches.

Software reaches the register through a plain write strobe and a read-back bus. The timer value, the PWM timebase and the period-start pulse come from timers outside the block. The pin input is expected to be already synchronized to `clk`. Pin direction control lives elsewhere.

Top module: `ccp_unit`

## Requirements
- R1: After reset, `reg_rd_data` is 0, `pin_out` is 0 and `irq_flag` is 0.
- R2: When `reg_wr_en` is high at a clock edge, all 16 bits of `reg_wr_data` load into the register and appear on `reg_rd_data` after that edge. A write beats a capture event in the same cycle.
- R3: Mode 4'b0100 captures on a falling pin edge and mode 4'b0101 captures on a rising pin edge. An edge is a `pin_in` sample that differs from the sample taken one cycle earlier. The register takes the `tmr_val` present in that cycle. In capture modes `pin_out` keeps its level.
- R4: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th rising edge. Any change of `mode` restarts the edge count, and an edge in the same cycle as the change is not counted.
- R5: In modes 4'b1000, 4'b1001 and 4'b1010, a match occurs whenever `tmr_val` equals the register. On a match `pin_out` becomes 1, becomes 0, or keeps its level, respectively, one cycle later.
- R6: `irq_flag` sets after any capture event or compare match and stays set until `irq_clr`. If a set and a clear happen in the same cycle, the set wins.
- R7: In modes 4'b11xx, a cycle with `pwm_period_start` high loads the active duty from register bits [9:0]. `pin_out` is then 1 in the next cycle, or 0 if the duty is zero. `pin_out` drops to 0 the cycle after `pwm_base` equals the active duty, so a duty at or beyond the period length gives a constant 1.
- R8: A register write during a PWM period does not change that period's waveform. The new duty takes effect at the next period start.
- R9: Mode 4'b0000 and the unused codes (4'b0001 to 4'b0011, 4'b1011) force `pin_out` to 0 one cycle later. In these codes no capture or match occurs, so the register and `irq_flag` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Function select (see requirements) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | Register write value |
| reg_rd_data | output | 16 | Register contents |
| tmr_val | input | 16 | Free-running timer value |
| pwm_base | input | 10 | PWM timebase (period timer and 2 fractional bits) |
| pwm_period_start | input | 1 | High in the first cycle of each PWM period |
| pin_in | input | 1 | Synchronized pin level |
| pin_out | output | 1 | Pin drive level |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky capture/match flag |

## Verification
The bench targets prescaler restarts. If the count were not cleared on a mode change, a capture would fire after two or three new edges instead of four. It drives a write and a rising edge in the same cycle; a design that gave capture priority would show the timer value instead of the written word. It rewrites the duty in the middle of a PWM period, which a design with a single duty register would reveal as a shortened or stretched pulse in that period. It also covers zero duty, duty beyond the period and reserved mode codes; mistakes there show up as a spurious pulse, a dropped constant high, or an undriven-low pin that stays high.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    typedef enum logic [3:0] {
        MODE_OFF       = 4'b0000,
        MODE_CAP_FALL  = 4'b0100,
        MODE_CAP_RISE  = 4'b0101,
        MODE_CAP_DIV4  = 4'b0110,
        MODE_CAP_DIV16 = 4'b0111,
        MODE_CMP_HI    = 4'b1000,
        MODE_CMP_LO    = 4'b1001,
        MODE_CMP_FLAG  = 4'b1010
    } ccp_mode_e;

    function automatic logic is_cap(input logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic logic is_cmp(input logic [3:0] m);
        return (m == MODE_CMP_HI) || (m == MODE_CMP_LO) || (m == MODE_CMP_FLAG);
    endfunction

    function automatic logic is_pwm(input logic [3:0] m);
        return m[3:2] == 2'b11;
    endfunction

endpackage

// File: rtl/ccp_evt_presc.sv
module ccp_evt_presc
    import ccp_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [3:0] mode,
    input  logic       mode_chg,
    output logic       evt_o
);
    localparam logic [DIV_W-1:0] LIM_4   = DIV_W'(3);
    localparam logic [DIV_W-1:0] LIM_MAX = {DIV_W{1'b1}};

    typedef struct packed {
        logic             pin;
        logic [DIV_W-1:0] cnt;
    } presc_st_t;

    presc_st_t st_d, st_q;
    logic             rise, fall;
    logic [DIV_W-1:0] lim;

    always_comb begin
        st_d     = st_q;
        st_d.pin = pin_in;
        rise     = pin_in & ~st_q.pin;
        fall     = ~pin_in & st_q.pin;
        lim      = (mode == MODE_CAP_DIV4) ? LIM_4 : LIM_MAX;
        evt_o    = 1'b0;
        if (mode_chg || !is_cap(mode)) begin
            st_d.cnt = '0;
        end else begin
            case (mode)
                MODE_CAP_FALL: evt_o = fall;
                MODE_CAP_RISE: evt_o = rise;
                default: begin
                    if (rise) begin
                        if (st_q.cnt == lim) begin
                            evt_o    = 1'b1;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    cnt_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (st_q.cnt == '0));

    // R4
    cnt_div4_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAP_DIV4 && !mode_chg) |-> (st_q.cnt <= LIM_4));

endmodule

// File: rtl/ccp_cmp.sv
module ccp_cmp
    import ccp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic [3:0]       mode,
    input  logic [TMR_W-1:0] cmp_val,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic             pin_cur,
    output logic             hit_o,
    output logic             pin_next_o
);
    always_comb begin
        hit_o      = is_cmp(mode) && (tmr_val == cmp_val);
        pin_next_o = pin_cur;
        if (hit_o) begin
            case (mode)
                MODE_CMP_HI: pin_next_o = 1'b1;
                MODE_CMP_LO: pin_next_o = 1'b0;
                default:     pin_next_o = pin_cur;
            endcase
        end
    end
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
    parameter int PWM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             period_start,
    input  logic [PWM_W-1:0] base,
    input  logic [PWM_W-1:0] duty_in,
    output logic             lvl_o
);
    typedef struct packed {
        logic [PWM_W-1:0] duty;
        logic             lvl;
    } pwm_st_t;

    pwm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.lvl = 1'b0;
        end else if (period_start) begin
            st_d.duty = duty_in;
            st_d.lvl  = (duty_in != '0);
        end else if (base == st_q.duty) begin
            st_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    // R7
    pwm_no_midrise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && !lvl_o) |=> !lvl_o);

    // R8
    pwm_duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(st_q.duty));

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
    import ccp_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int PWM_W = 10,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode,
    input  logic             reg_wr_en,
    input  logic [TMR_W-1:0] reg_wr_data,
    output logic [TMR_W-1:0] reg_rd_data,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic [PWM_W-1:0] pwm_base,
    input  logic             pwm_period_start,
    input  logic             pin_in,
    output logic             pin_out,
    input  logic             irq_clr,
    output logic             irq_flag
);
    typedef struct packed {
        logic [TMR_W-1:0] data;
        logic [3:0]       mode;
        logic             cpin;
        logic             sel_pwm;
        logic             flag;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic mode_chg, cap_evt, cmp_hit, cmp_pin, pwm_lvl, off_mode;

    assign mode_chg = (mode != st_q.mode);
    assign off_mode = !is_cap(mode) && !is_cmp(mode) && !is_pwm(mode);

    ccp_evt_presc #(.DIV_W(DIV_W)) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .mode     (mode),
        .mode_chg (mode_chg),
        .evt_o    (cap_evt)
    );

    ccp_cmp #(.TMR_W(TMR_W)) cmp_i (
        .mode       (mode),
        .cmp_val    (st_q.data),
        .tmr_val    (tmr_val),
        .pin_cur    (st_q.cpin),
        .hit_o      (cmp_hit),
        .pin_next_o (cmp_pin)
    );

    ccp_pwm #(.PWM_W(PWM_W)) pwm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (is_pwm(mode)),
        .period_start (pwm_period_start),
        .base         (pwm_base),
        .duty_in      (st_q.data[PWM_W-1:0]),
        .lvl_o        (pwm_lvl)
    );

    always_comb begin
        st_d         = st_q;
        st_d.mode    = mode;
        st_d.sel_pwm = is_pwm(mode);
        if (reg_wr_en)    st_d.data = reg_wr_data;
        else if (cap_evt) st_d.data = tmr_val;
        if (off_mode || is_pwm(mode)) st_d.cpin = 1'b0;
        else if (is_cmp(mode))        st_d.cpin = cmp_pin;
        if (cap_evt || cmp_hit) st_d.flag = 1'b1;
        else if (irq_clr)       st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rd_data = st_q.data;
    assign irq_flag    = st_q.flag;
    assign pin_out     = st_q.sel_pwm ? pwm_lvl : st_q.cpin;

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data == $past(reg_wr_data)));

    // R3
    cap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !reg_wr_en) |=> (reg_rd_data == $past(tmr_val)));

    // R5
    cmp_drive_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMP_HI && tmr_val == reg_rd_data) |=> pin_out);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R9
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_cap(mode) && !is_cmp(mode) && !is_pwm(mode)) |=> !pin_out);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_cap(mode) && !is_cmp(mode) && !is_pwm(mode) && !reg_wr_en && !irq_clr)
            |=> ($stable(reg_rd_data) && $stable(irq_flag)));

endmodule

// File: tb/ccp_unit_tb_top.sv
`timescale 1ns/1ps
module ccp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic [15:0] tmr_val = '0;
    logic [9:0]  pwm_base = '0;
    logic        pwm_period_start = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        irq_clr = 1'b0;
    logic        irq_flag;

    int    errs = 0, checks = 0, cyc = 0;
    string cur_req = "R1";
    bit    pwm_run = 0;
    bit    model_on = 0;

    always #2.5 clk = ~clk;

    ccp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .tmr_val(tmr_val),
        .pwm_base(pwm_base), .pwm_period_start(pwm_period_start), .pin_in(pin_in),
        .pin_out(pin_out), .irq_clr(irq_clr), .irq_flag(irq_flag)
    );

    // behavioural reference
    logic [15:0] m_reg;
    logic [9:0]  m_duty;
    logic [3:0]  m_mode;
    logic        m_prev_pin, m_cpin, m_flag, m_pwm_hi, m_pwm_sel;
    int          m_edges;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = 0; m_duty = 0; m_mode = 0; m_prev_pin = 0; m_cpin = 0;
            m_flag = 0; m_pwm_hi = 0; m_pwm_sel = 0; m_edges = 0;
        end else begin
            bit capt, match, rising, falling, cap_m, cmp_m, pwm_m, changed;
            int n;
            changed = (mode != m_mode);
            cap_m   = (mode >= 4 && mode <= 7);
            cmp_m   = (mode >= 8 && mode <= 10);
            pwm_m   = (mode >= 12);
            rising  = pin_in && !m_prev_pin;
            falling = !pin_in && m_prev_pin;
            capt    = 0;
            if (changed || !cap_m) m_edges = 0;
            else if (mode == 4) capt = falling;
            else if (mode == 5) capt = rising;
            else if (rising) begin
                n = (mode == 6) ? 4 : 16;
                m_edges++;
                if (m_edges % n == 0) begin capt = 1; m_edges = 0; end
            end
            match = cmp_m && (tmr_val == m_reg);
            if (!pwm_m) m_pwm_hi = 0;
            else if (pwm_period_start) begin
                m_duty = m_reg[9:0]; m_pwm_hi = (m_reg[9:0] != 0);
            end else if (pwm_base == m_duty) m_pwm_hi = 0;
            if (!cap_m && !cmp_m) m_cpin = 0;
            else if (match && mode == 8) m_cpin = 1;
            else if (match && mode == 9) m_cpin = 0;
            if (capt || match) m_flag = 1;
            else if (irq_clr)  m_flag = 0;
            if (reg_wr_en) m_reg = reg_wr_data;
            else if (capt) m_reg = tmr_val;
            m_pwm_sel  = pwm_m;
            m_mode     = mode;
            m_prev_pin = pin_in;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk(cur_req, "reg", int'(reg_rd_data), int'(m_reg));
            chk(cur_req, "pin", int'(pin_out), int'(m_pwm_sel ? m_pwm_hi : m_cpin));
            chk(cur_req, "flag", int'(irq_flag), int'(m_flag));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=60000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        tmr_val = tmr_val + 1;
        if (pwm_run) begin
            pwm_base = (pwm_base == 10'd39) ? 10'd0 : pwm_base + 1;
            pwm_period_start = (pwm_base == 10'd0);
        end else begin
            pwm_period_start = 0;
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [15:0] v);
        reg_wr_en = 1; reg_wr_data = v; step(); reg_wr_en = 0;
    endtask

    task automatic edge_up();
        pin_in = 1; step(); pin_in = 0; step();
    endtask

    task automatic pwm_period(input int exp, input string req, input int wr_at, input logic [15:0] wv);
        int hi = 0;
        while (pwm_period_start !== 1'b1) step();
        for (int i = 0; i < 40; i++) begin
            reg_wr_en = (i == wr_at);
            reg_wr_data = wv;
            step();
            hi += pin_out;
        end
        reg_wr_en = 0;
        chk(req, "pwm high count", hi, exp);
    endtask

    initial begin
        logic [15:0] t, keep;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset reg", int'(reg_rd_data), 0);
        chk("R1", "reset pin", int'(pin_out), 0);
        chk("R1", "reset flag", int'(irq_flag), 0);
        rst_n = 1; model_on = 1;
        steps(2);

        cur_req = "R2";
        wr(16'hA55A);
        chk("R2", "write readback", int'(reg_rd_data), 16'hA55A);

        cur_req = "R3";
        mode = 4'b0101; steps(3);
        pin_in = 1; t = tmr_val; step();
        chk("R3", "rise capture", int'(reg_rd_data), int'(t));
        steps(3); irq_clr = 1; step(); irq_clr = 0;
        chk("R6", "flag cleared", int'(irq_flag), 0);
        mode = 4'b0100; steps(3);
        pin_in = 0; t = tmr_val; step();
        chk("R3", "fall capture", int'(reg_rd_data), int'(t));
        chk("R6", "flag after capture", int'(irq_flag), 1);
        mode = 4'b0101; steps(3);
        cur_req = "R2";
        pin_in = 1; reg_wr_en = 1; reg_wr_data = 16'hBEEF; step(); reg_wr_en = 0;
        chk("R2", "write beats capture", int'(reg_rd_data), 16'hBEEF);
        pin_in = 0; step();

        cur_req = "R4";
        mode = 4'b0110; steps(2); wr(16'h0000);
        for (int k = 0; k < 3; k++) edge_up();
        chk("R4", "no capture before 4th", int'(reg_rd_data), 0);
        pin_in = 1; t = tmr_val; step(); pin_in = 0; step();
        chk("R4", "4th edge capture", int'(reg_rd_data), int'(t));
        edge_up(); edge_up();
        mode = 4'b0111; step(); mode = 4'b0110; step();
        keep = reg_rd_data;
        for (int k = 0; k < 3; k++) edge_up();
        chk("R4", "count restarted", int'(reg_rd_data), int'(keep));
        pin_in = 1; t = tmr_val; step(); pin_in = 0; step();
        chk("R4", "fresh 4th edge", int'(reg_rd_data), int'(t));
        mode = 4'b0111; pin_in = 1; step(); pin_in = 0; step();
        for (int k = 0; k < 15; k++) edge_up();
        pin_in = 1; t = tmr_val; step(); pin_in = 0; step();
        chk("R4", "16th edge capture", int'(reg_rd_data), int'(t));

        cur_req = "R5";
        mode = 4'b1000; irq_clr = 1; step(); irq_clr = 0;
        wr(tmr_val + 16'd8); steps(12);
        chk("R5", "match drives high", int'(pin_out), 1);
        chk("R6", "match sets flag", int'(irq_flag), 1);
        mode = 4'b1001; wr(tmr_val + 16'd6); steps(10);
        chk("R5", "match drives low", int'(pin_out), 0);
        mode = 4'b1000; wr(tmr_val + 16'd4); steps(8);
        mode = 4'b1010; irq_clr = 1; step(); irq_clr = 0;
        wr(tmr_val + 16'd5); steps(9);
        chk("R5", "match keeps pin", int'(pin_out), 1);
        chk("R6", "flag-only match", int'(irq_flag), 1);

        cur_req = "R9";
        mode = 4'b0000; step();
        chk("R9", "off forces low", int'(pin_out), 0);
        irq_clr = 1; step(); irq_clr = 0;
        mode = 4'b0010; keep = reg_rd_data; steps(2);
        edge_up();
        chk("R9", "reserved no capture", int'(reg_rd_data), int'(keep));
        chk("R9", "reserved no flag", int'(irq_flag), 0);

        cur_req = "R6";
        mode = 4'b0101; steps(2);
        pin_in = 1; irq_clr = 1; step(); irq_clr = 0; pin_in = 0;
        chk("R6", "set wins over clear", int'(irq_flag), 1);
        step();

        cur_req = "R7";
        mode = 4'b1100; wr(16'd10); pwm_run = 1;
        pwm_period(10, "R7", -1, 16'd10);
        cur_req = "R8";
        pwm_period(10, "R8", 20, 16'd25);
        pwm_period(25, "R8", -1, 16'd25);
        cur_req = "R7";
        wr(16'd0);
        pwm_period(0, "R7", -1, 16'd0);
        wr(16'd300);
        pwm_period(40, "R7", -1, 16'd0);
        mode = 4'b1111; wr(16'd1);
        pwm_period(1, "R7", -1, 16'd0);

        cur_req = "R9";
        mode = 4'b0000; step();
        chk("R9", "off after PWM", int'(pin_out), 0);
        pwm_run = 0; steps(4);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule